// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt causes from a bus bridge into one 32-bit status word. The causes are error and power events that arrive as single-cycle pulses, four level-sensitive legacy interrupt lines, a virtual-to-physical event, and four software interrupts raised through a register write. Pulse causes stay set until software clears them. Legacy-line bits are set again for as long as their line stays high.

Two enable masks gate the status word. One serves the host side and the other serves the local back-end processor. Each mask has a write-one-to-set address and a write-one-to-clear address, and each drives its own active-high level interrupt output. Reading the clear address of a mask returns the status word ANDed with that mask. This lets a handler find the pending causes with one read.

The block is accessed over a plain register bus with address, write enable, write data and a combinational read-data path.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the status word and both masks are zero, `host_irq` and `local_irq` are low, and a read of offset 0x00 returns the `REV_ID` parameter.
- R2: Only these status bits exist, and every other bit reads 0:
  - bit 0 is set by `err_evt[0]`, bit 1 by `err_evt[1]`, bit 2 by `err_evt[2]`, bit 5 by `err_evt[3]` and bit 6 by `err_evt[4]`.
  - bits 16..19 follow `legacy_int[0..3]`.
  - bit 20 is set by `pme_evt`.
  - bits 24..27 are the software interrupts.
  - bit 31 is set by `v2p_evt`.
  - A pulse on an input sets its bit, and the bit reads 1 from the cycle after the input was sampled.
- R3: A write to offset 0x10 sets every implemented status bit whose data bit is 1. Reads of 0x10 and of 0x14 return the raw status.
- R4: A write to offset 0x14 clears every status bit whose data bit is 1 and leaves the other bits unchanged.
- R5: Mask writes work as follows, and a 0 data bit has no effect in every case:
  - Offset 0x20 sets host-mask bits and offset 0x24 clears them.
  - Offset 0x30 sets back-end-mask bits and offset 0x34 clears them.
  - Reading 0x20 or 0x30 returns that mask, which holds implemented bits only.
- R6: While a `legacy_int` line is high, its status bit reads 1 in the cycle after a clear write to it. Once the line is low, a clear removes the bit.
- R7: A read of 0x24 returns the status ANDed with the host mask. A read of 0x34 returns the status ANDed with the back-end mask.
- R8: `local_irq` is high exactly when (status AND back-end mask) is nonzero. `host_irq` is high exactly when (status AND host mask) is nonzero.
- R9: When a set request and a clear request reach the same status bit in the same cycle, the bit ends up 1.
- R10: Reads of any offset other than those above return 0. Writes to 0x00 or to an unmapped offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| err_evt | input | 5 | Error and power-change event pulses |
| legacy_int | input | 4 | Level legacy interrupt lines A..D |
| pme_evt | input | 1 | Power-management event pulse |
| v2p_evt | input | 1 | Virtual-to-physical event pulse |
| host_irq | output | 1 | Host-side level interrupt |
| local_irq | output | 1 | Back-end processor level interrupt |

## Verification
The assertions take for granted that all inputs are synchronous to `clk` and steady at the sampling edge, and that only one register write happens per cycle. The bench changes every input on the falling edge and holds `reg_we` for exactly one cycle per write. Pulse inputs are kept high for one cycle, so a set-versus-clear collision only occurs where a test builds it on purpose. Legacy lines are held for several cycles to exercise the re-set behaviour.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int N_ERR  = 5;
  localparam int N_LEG  = 4;
  localparam int LEG_LO = 16;
  localparam int PME_B  = 20;
  localparam int V2P_B  = 31;

  localparam logic [DW-1:0] STAT_IMPL = 32'h8F1F_0067;

  localparam logic [AW-1:0] A_REV    = 8'h00;
  localparam logic [AW-1:0] A_ST_SET = 8'h10;
  localparam logic [AW-1:0] A_ST_CLR = 8'h14;
  localparam logic [AW-1:0] A_HM_SET = 8'h20;
  localparam logic [AW-1:0] A_HM_CLR = 8'h24;
  localparam logic [AW-1:0] A_BM_SET = 8'h30;
  localparam logic [AW-1:0] A_BM_CLR = 8'h34;

  // Status bit that each error pulse sets (error index -> status bit)
  function automatic int err_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 5;
      default: return 6;
    endcase
  endfunction

  // Place the hardware causes into status-word positions
  function automatic logic [DW-1:0] place_events(
      input logic [N_ERR-1:0] err, input logic [N_LEG-1:0] lvl,
      input logic pme, input logic v2p);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < N_ERR; i++) v[err_pos(i)] = err[i];
    for (int k = 0; k < N_LEG; k++) v[LEG_LO+k] = lvl[k];
    v[PME_B] = pme;
    v[V2P_B] = v2p;
    return v;
  endfunction

  // New status from old status plus set and clear requests; set wins
  function automatic logic [DW-1:0] next_status(
      input logic [DW-1:0] cur, input logic [DW-1:0] setv, input logic [DW-1:0] clrv);
    return ((cur & ~clrv) | setv) & STAT_IMPL;
  endfunction

  function automatic logic [DW-1:0] gate(input logic [DW-1:0] st, input logic [DW-1:0] m);
    return st & m;
  endfunction
endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status
  import irq_agg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] hw_set,
  input  logic          sw_set_we,
  input  logic          sw_clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  always_comb begin
    set_vec = (hw_set | (sw_set_we ? wdata : '0)) & STAT_IMPL;
    clr_vec = sw_clr_we ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= next_status(status, set_vec, clr_vec);
  end

  // R2: unimplemented positions never hold a 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~STAT_IMPL) == '0);

  // R9: every requested set is visible next cycle, whatever the clears do
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R4: a clear of a bit with no set request leaves it at 0
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_we && ((wdata & ~set_vec & STAT_IMPL) != '0))
      |=> ((status & $past(wdata & ~set_vec)) == '0));
endmodule

// File: rtl/irq_agg_mask.sv
module irq_agg_mask
  import irq_agg_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask
);
  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] clr_bits;

  assign set_bits = wr_set ? (wdata & IMPL) : '0;
  assign clr_bits = wr_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_bits) & ~clr_bits;
  end

  // R5: with no write to this pair the mask holds
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr) |=> $stable(mask));

  // R5: a set write turns on the requested implemented bits
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !wr_clr) |=> ((mask & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  // R5: a clear write turns the requested bits off
  a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set) |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/irq_agg_readmux.sv
module irq_agg_readmux
  import irq_agg_pkg::*;
#(
  parameter logic [DW-1:0] REV_ID = 32'h0001_0002
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] host_mask,
  input  logic [DW-1:0] be_mask,
  output logic [DW-1:0] rdata
);
  always_comb begin
    case (addr)
      A_REV:              rdata = REV_ID;
      A_ST_SET, A_ST_CLR: rdata = status;
      A_HM_SET:           rdata = host_mask;
      A_HM_CLR:           rdata = gate(status, host_mask);
      A_BM_SET:           rdata = be_mask;
      A_BM_CLR:           rdata = gate(status, be_mask);
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0001_0002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [4:0]    err_evt,
  input  logic [3:0]    legacy_int,
  input  logic          pme_evt,
  input  logic          v2p_evt,
  output logic          host_irq,
  output logic          local_irq
);
  logic          wr_st_set, wr_st_clr, wr_hm_set, wr_hm_clr, wr_bm_set, wr_bm_clr;
  logic [DW-1:0] hw_set;
  logic [DW-1:0] status;
  logic [DW-1:0] host_mask;
  logic [DW-1:0] be_mask;
  logic [DW-1:0] host_pend;
  logic [DW-1:0] be_pend;

  assign wr_st_set = reg_we && (reg_addr == A_ST_SET);
  assign wr_st_clr = reg_we && (reg_addr == A_ST_CLR);
  assign wr_hm_set = reg_we && (reg_addr == A_HM_SET);
  assign wr_hm_clr = reg_we && (reg_addr == A_HM_CLR);
  assign wr_bm_set = reg_we && (reg_addr == A_BM_SET);
  assign wr_bm_clr = reg_we && (reg_addr == A_BM_CLR);

  assign hw_set = place_events(err_evt, legacy_int, pme_evt, v2p_evt);

  irq_agg_status u_status (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
    .sw_set_we(wr_st_set), .sw_clr_we(wr_st_clr), .wdata(reg_wdata),
    .status(status)
  );

  irq_agg_mask #(.WIDTH(DW), .IMPL(STAT_IMPL)) u_host_mask (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_hm_set), .wr_clr(wr_hm_clr),
    .wdata(reg_wdata), .mask(host_mask)
  );

  irq_agg_mask #(.WIDTH(DW), .IMPL(STAT_IMPL)) u_be_mask (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_bm_set), .wr_clr(wr_bm_clr),
    .wdata(reg_wdata), .mask(be_mask)
  );

  irq_agg_readmux #(.REV_ID(REV_ID)) u_rmux (
    .addr(reg_addr), .status(status), .host_mask(host_mask),
    .be_mask(be_mask), .rdata(reg_rdata)
  );

  assign host_pend = gate(status, host_mask);
  assign be_pend   = gate(status, be_mask);
  assign host_irq  = |host_pend;
  assign local_irq = |be_pend;

  // R8: no enabled back-end source means no local interrupt
  a_r8_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (be_mask == '0) |-> !local_irq);

  // R8: no enabled host source means no host interrupt
  a_r8_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mask == '0) |-> !host_irq);

  // R6: a high legacy line shows up in status on the next cycle, clear or not
  a_r6_level_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[LEG_LO +: N_LEG] & $past(legacy_int)) == $past(legacy_int)));

  // R10: a write to the revision offset leaves both masks unchanged
  a_r10_rev_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_REV) |=> ($stable(host_mask) && $stable(be_mask)));
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REV = 32'h0001_0002;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  err_evt = '0;
  logic [3:0]  legacy_int = '0;
  logic        pme_evt = 1'b0;
  logic        v2p_evt = 1'b0;
  logic        host_irq, local_irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg_top #(.REV_ID(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt(err_evt),
    .legacy_int(legacy_int), .pme_evt(pme_evt), .v2p_evt(v2p_evt),
    .host_irq(host_irq), .local_irq(local_irq)
  );

  // Vector: {waddr, wdata, raddr, expected rdata, expected local_irq, expected host_irq}
  localparam logic [81:0] VEC [NV] = '{
    {8'h10, 32'hFFFF_FFFF, 8'h10, 32'h8F1F_0067, 1'b0, 1'b0},  // R3 R2
    {8'h14, 32'h0000_FFFF, 8'h10, 32'h8F1F_0000, 1'b0, 1'b0},  // R4
    {8'h30, 32'h0101_0000, 8'h30, 32'h0101_0000, 1'b1, 1'b0},  // R5 R8
    {8'h34, 32'h0000_0000, 8'h30, 32'h0101_0000, 1'b1, 1'b0},  // R5 zero no-op
    {8'h14, 32'h0001_0000, 8'h34, 32'h0100_0000, 1'b1, 1'b0},  // R7
    {8'h20, 32'hFFFF_FFFF, 8'h20, 32'h8F1F_0067, 1'b1, 1'b1},  // R5
    {8'h24, 32'h0F00_0000, 8'h20, 32'h801F_0067, 1'b1, 1'b1},  // R5
    {8'h00, 32'hFFFF_FFFF, 8'h24, 32'h801E_0000, 1'b1, 1'b1},  // R10 R7
    {8'h44, 32'hFFFF_FFFF, 8'h44, 32'h0000_0000, 1'b1, 1'b1},  // R10
    {8'h14, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000, 1'b0, 1'b0}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 rev", r, REV);
    rd(8'h10, r); check("R1 status", r, 32'h0);
    rd(8'h20, r); check("R1 host mask", r, 32'h0);
    rd(8'h30, r); check("R1 be mask", r, 32'h0);
    check("R1 irqs", {30'b0, local_irq, host_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][81:74], VEC[i][73:42]);
      rd(VEC[i][41:34], r);
      check($sformatf("vec%0d rdata", i), r, VEC[i][33:2]);
      check($sformatf("vec%0d R8 irqs", i), {30'b0, local_irq, host_irq}, {30'b0, VEC[i][1:0]});
    end

    // R2 event mapping: all pulses for one cycle
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    @(negedge clk);
    err_evt = 5'b11111; pme_evt = 1'b1; v2p_evt = 1'b1;
    @(negedge clk);
    err_evt = '0; pme_evt = 1'b0; v2p_evt = 1'b0;
    rd(8'h10, r); check("R2 pulse map", r, 32'h8010_0067);
    @(negedge clk);
    rd(8'h10, r); check("R2 sticky", r, 32'h8010_0067);
    check("R8 masks off", {30'b0, local_irq, host_irq}, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, r); check("R4 all clear", r, 32'h0);

    // R6 level lines
    @(negedge clk);
    legacy_int = 4'b0101;
    @(negedge clk);
    rd(8'h10, r); check("R6 level set", r, 32'h0005_0000);
    wr(8'h30, 32'h0004_0000);
    check("R8 local on level", {31'b0, local_irq}, 32'h1);
    wr(8'h14, 32'h000F_0000);
    rd(8'h10, r); check("R6 clear while high", r, 32'h0005_0000);
    legacy_int = 4'b0001;
    @(negedge clk);
    wr(8'h14, 32'h000F_0000);
    rd(8'h10, r); check("R6 clear after drop", r, 32'h0001_0000);
    rd(8'h34, r); check("R7 be pend", r, 32'h0);
    check("R8 local off", {31'b0, local_irq}, 32'h0);
    legacy_int = 4'b0000;
    @(negedge clk);
    wr(8'h14, 32'hFFFF_FFFF);

    // R9 set beats clear in same cycle
    @(negedge clk);
    reg_addr = 8'h14; reg_wdata = 32'h0000_0003; reg_we = 1'b1; err_evt = 5'b00001;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; err_evt = '0;
    rd(8'h10, r); check("R9 set wins", r, 32'h0000_0001);
    @(negedge clk);
    reg_addr = 8'h10; reg_wdata = 32'h0100_0000; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(8'h10, r); check("R3 sw int", r, 32'h0100_0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule